// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block orders the shutdown and restart of a clock generator around an asynchronous, active-low power-down request. The request is resynchronized to the internal CPU clock. The sequencer then parks the gated CPU and PCI clock outputs low, and each output finishes its current pulse first. Only when both outputs sit low does it turn off the VCO and the crystal oscillator enables. The two enables are modelled only as logic levels.

When the request is withdrawn, the crystal enable returns first. The VCO enable follows one timer tick later. The outputs stay held for a programmable number of ticks of a slow, always-on timing clock, then they are released. The tick count is a parameter, so the millisecond-scale start-up bound can be shortened in simulation. The CPU-stop and PCI-stop inputs park their own output while the block runs. They have no influence on the sequence while the outputs are held. The CPU clock is the sequencer's reference and is taken to keep running while the enables are off.

Top module: `clkgen_pwrdn_seq`

## Requirements
- R1: Out of reset osc_en and vco_en are 1, out_hold is 0, cpu_clk_out toggles every cpu_clk cycle and pci_clk_out has a period of 2*PCI_HALF cpu_clk cycles.
- R2: pd_n passes a two-stage synchronizer on cpu_clk. When pd_n falls between two rising edges, cpu_clk_out shows exactly two more rising edges and then stays low.
- R3: osc_en and vco_en fall only after out_hold is 1 and both cpu_clk_out and pci_clk_out are parked low. While vco_en is 0, out_hold stays 1 and neither output toggles.
- R4: No output pulse is clipped. Every cpu_clk_out high phase lasts half a cpu_clk period and every pci_clk_out high phase lasts PCI_HALF cpu_clk periods. No low phase is shorter than the matching high phase.
- R5: A timer rising edge acts on the third cpu_clk rising edge after it. On restart osc_en rises while vco_en is still 0, and vco_en rises on exactly one acting timer edge after that.
- R6: out_hold falls on the SETTLE_TICKS-th acting timer edge after vco_en rises, and both outputs then run at their normal rates.
- R7: A request withdrawn while outputs are being parked does not cut the shutdown short. osc_en still falls once before the restart sequence runs.
- R8: A request reasserted during restart, before out_hold falls, turns osc_en and vco_en back off. out_hold stays 1 and no output pulse appears.
- R9: cpu_stop_n and pci_stop_n have no effect while out_hold is 1. osc_en, vco_en, out_hold and both outputs are unchanged by their toggling.
- R10: While running, cpu_stop_n low parks only cpu_clk_out and pci_stop_n low parks only pci_clk_out. Each input passes its own two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Internal CPU clock, sequencer reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_clk | input | 1 | Slow always-on timing clock |
| pd_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | Asynchronous CPU clock stop, active low |
| pci_stop_n | input | 1 | Asynchronous PCI clock stop, active low |
| cpu_clk_out | output | 1 | Gated CPU clock output |
| pci_clk_out | output | 1 | Gated PCI clock output |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| out_hold | output | 1 | High while the gated outputs are held low |

## Verification
Two collisions matter here. The first is a timer tick landing in the same cycle as a request edge. The second is a PCI phase wrap landing in the cycle where parking begins. The bench moves the request edge across every cycle of the 14-cycle timer period and the 4-cycle PCI period, and it reasserts the request both just after the crystal restarts and just after the VCO restarts. The bench counts acting timer edges from its own knowledge of when it toggled the timer. Each enable change and each hold release is judged against that count. Every output pulse has its high and low widths timed against the nominal values.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_PARK,
    ST_XTAL_OFF,
    ST_XTAL_UP,
    ST_SETTLE
  } pds_state_e;

  // next level of the divided PCI clock at a phase wrap: a high phase
  // always completes, a new one starts only when running is allowed
  function automatic logic pci_level_next(input logic cur, input logic run);
    return cur ? 1'b0 : run;
  endfunction

  function automatic logic xtal_on(input pds_state_e s);
    return s != ST_XTAL_OFF;
  endfunction

  function automatic logic vco_on(input pds_state_e s);
    return (s != ST_XTAL_OFF) && (s != ST_XTAL_UP);
  endfunction

endpackage

// File: rtl/pds_sync.sv
module pds_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[i] <= RST_VAL;
        else        sr[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[i] <= RST_VAL;
        else        sr[i] <= sr[i-1];
      end
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/pds_tick.sv
module pds_tick #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tmr_clk,
  output logic tick
);
  logic tmr_s;
  logic tmr_prev;

  pds_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(tmr_clk), .q(tmr_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_prev <= 1'b0;
    else        tmr_prev <= tmr_s;
  end

  assign tick = tmr_s & ~tmr_prev;
endmodule

// File: rtl/pds_outgate.sv
module pds_outgate import pds_pkg::*; #(
  parameter int PCI_HALF = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_cpu,
  input  logic run_pci,
  output logic cpu_out,
  output logic pci_out,
  output logic cpu_en,
  output logic parked
);
  localparam int PW = (PCI_HALF > 1) ? $clog2(PCI_HALF) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PCI_HALF - 1);

  logic          cpu_en_q;
  logic          pci_q;
  logic [PW-1:0] phase;

  // enable changes only while clk is low, so the gated clock never clips
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) cpu_en_q <= 1'b1;
    else        cpu_en_q <= run_cpu;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      pci_q <= 1'b0;
    end else if (phase == PH_LAST) begin
      phase <= '0;
      pci_q <= pci_level_next(pci_q, run_pci);
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign cpu_out = clk & cpu_en_q;
  assign pci_out = pci_q;
  assign cpu_en  = cpu_en_q;
  assign parked  = ~cpu_en_q & ~pci_q;
endmodule

// File: rtl/clkgen_pwrdn_seq.sv
module clkgen_pwrdn_seq import pds_pkg::*; #(
  parameter int SYNC_STAGES  = 2,
  parameter int PCI_HALF     = 1,
  parameter int SETTLE_TICKS = 96
) (
  input  logic cpu_clk,
  input  logic rst_n,
  input  logic tmr_clk,
  input  logic pd_n,
  input  logic cpu_stop_n,
  input  logic pci_stop_n,
  output logic cpu_clk_out,
  output logic pci_clk_out,
  output logic osc_en,
  output logic vco_en,
  output logic out_hold
);
  localparam int N_ASYNC = 3;
  localparam int CW = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_TICKS - 1);

  function automatic logic settle_last(input logic [CW-1:0] c);
    return c == CNT_LAST;
  endfunction

  logic [N_ASYNC-1:0] async_in;
  logic [N_ASYNC-1:0] sync_out;
  logic pd_s, cpu_stop_s, pci_stop_s;
  logic tmr_tick;
  logic run_cpu, run_pci;
  logic cpu_gate_en, outs_parked;

  pds_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign async_in = {pci_stop_n, cpu_stop_n, pd_n};

  for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
    pds_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(cpu_clk), .rst_n(rst_n), .d(async_in[g]), .q(sync_out[g])
    );
  end

  assign pd_s       = sync_out[0];
  assign cpu_stop_s = sync_out[1];
  assign pci_stop_s = sync_out[2];

  pds_tick #(.STAGES(SYNC_STAGES)) u_tick (
    .clk(cpu_clk), .rst_n(rst_n), .tmr_clk(tmr_clk), .tick(tmr_tick)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN:      if (!pd_s) state_d = ST_PARK;
      ST_PARK:     if (outs_parked) state_d = ST_XTAL_OFF;
      ST_XTAL_OFF: if (pd_s) state_d = ST_XTAL_UP;
      ST_XTAL_UP: begin
        if (!pd_s) state_d = ST_XTAL_OFF;
        else if (tmr_tick) begin
          state_d = ST_SETTLE;
          cnt_d   = '0;
        end
      end
      ST_SETTLE: begin
        if (!pd_s) state_d = ST_XTAL_OFF;
        else if (tmr_tick) begin
          if (settle_last(cnt_q)) state_d = ST_RUN;
          else                    cnt_d   = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_XTAL_OFF;
    endcase
  end

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign run_cpu = (state_q == ST_RUN) & pd_s & cpu_stop_s;
  assign run_pci = (state_q == ST_RUN) & pd_s & pci_stop_s;

  pds_outgate #(.PCI_HALF(PCI_HALF)) u_gate (
    .clk(cpu_clk), .rst_n(rst_n), .run_cpu(run_cpu), .run_pci(run_pci),
    .cpu_out(cpu_clk_out), .pci_out(pci_clk_out),
    .cpu_en(cpu_gate_en), .parked(outs_parked)
  );

  assign osc_en   = xtal_on(state_q);
  assign vco_en   = vco_on(state_q);
  assign out_hold = state_q != ST_RUN;
endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
  parameter int PCI_HALF = 1
) (
  input logic cpu_clk,
  input logic rst_n,
  input logic osc_en,
  input logic vco_en,
  input logic out_hold,
  input logic pci_clk_out,
  input logic cpu_gate_en,
  input logic tmr_tick
);
  localparam int HW = $clog2(PCI_HALF + 2);
  localparam logic [HW-1:0] HI_MAX = HW'(PCI_HALF + 1);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n)           hi_cnt <= '0;
    else if (pci_clk_out) hi_cnt <= (hi_cnt == HI_MAX) ? hi_cnt : hi_cnt + 1'b1;
    else                  hi_cnt <= '0;
  end

  p_off_after_park_r3: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $fell(osc_en) |-> (out_hold && !pci_clk_out && !cpu_gate_en));

  p_held_while_off_r3: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    !vco_en |-> out_hold);

  p_vco_after_osc_r5: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $rose(vco_en) |-> ($past(osc_en) && $past(tmr_tick)));

  p_release_on_tick_r6: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $fell(out_hold) |-> ($past(vco_en) && $past(tmr_tick)));

  p_pci_width_r4: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    (!pci_clk_out && hi_cnt != '0) |-> (hi_cnt == HW'(PCI_HALF)));
endmodule

bind clkgen_pwrdn_seq pds_checker #(.PCI_HALF(PCI_HALF)) u_chk (
  .cpu_clk(cpu_clk), .rst_n(rst_n), .osc_en(osc_en), .vco_en(vco_en),
  .out_hold(out_hold), .pci_clk_out(pci_clk_out),
  .cpu_gate_en(cpu_gate_en), .tmr_tick(tmr_tick)
);

// File: tb/sim_clkgen_pwrdn_seq.sv
`timescale 1ns/1ps
module sim_clkgen_pwrdn_seq;
  localparam int  CLK_PERIOD = 10;
  localparam real HALF       = CLK_PERIOD / 2.0;
  localparam int  PCI_HALF   = 2;
  localparam int  SETTLE     = 3;
  localparam int  TDIV       = 7;
  localparam int  WD_LIMIT   = 60000;

  logic cpu_clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_clk = 1'b0;
  logic pd_n = 1'b1;
  logic cpu_stop_n = 1'b1;
  logic pci_stop_n = 1'b1;
  logic cpu_clk_out, pci_clk_out, osc_en, vco_en, out_hold;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int rise_cyc = -100;
  int eff = 0;
  int tdiv_cnt = 0;
  int cpu_rises = 0;
  int pci_rises = 0;
  int osc_falls = 0;
  int wd = 0;
  real t_cr = -1.0, t_cf = -1.0, t_pr = -1.0, t_pf = -1.0;

  clkgen_pwrdn_seq #(.SYNC_STAGES(2), .PCI_HALF(PCI_HALF), .SETTLE_TICKS(SETTLE)) u0 (
    .cpu_clk(cpu_clk), .rst_n(rst_n), .tmr_clk(tmr_clk), .pd_n(pd_n),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .cpu_clk_out(cpu_clk_out), .pci_clk_out(pci_clk_out),
    .osc_en(osc_en), .vco_en(vco_en), .out_hold(out_hold)
  );

  always #(CLK_PERIOD/2) cpu_clk = ~cpu_clk;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // timer toggles on falling CPU edges; a rise acts on the third rising edge after it
  always @(negedge cpu_clk) begin
    tdiv_cnt++;
    if (tdiv_cnt == TDIV) begin
      tdiv_cnt = 0;
      tmr_clk = ~tmr_clk;
      if (tmr_clk) rise_cyc = cyc;
    end
  end

  always @(posedge cpu_clk) begin
    cyc <= cyc + 1;
    if (cyc + 1 == rise_cyc + 3) eff <= eff + 1;
    wd++;
    if (wd > WD_LIMIT) begin
      fails++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // pulse-width monitors (R4) and running-state check on each rise (R3)
  always @(posedge cpu_clk_out) begin
    cpu_rises++;
    if (t_cf >= 0.0)
      chk("R4 cpu low width ok", int'($realtime - t_cf >= HALF - 0.01), 1);
    t_cr = $realtime;
    #1;
    chk("R3 cpu pulse only while running", int'(osc_en && vco_en && !out_hold), 1);
  end
  always @(negedge cpu_clk_out) begin
    t_cf = $realtime;
    if (t_cr >= 0.0)
      chk("R4 cpu high width ps", $rtoi((t_cf - t_cr) * 1000.0 + 0.5), $rtoi(HALF * 1000.0));
  end
  always @(posedge pci_clk_out) begin
    pci_rises++;
    if (t_pf >= 0.0)
      chk("R4 pci low width ok", int'($realtime - t_pf >= PCI_HALF * CLK_PERIOD - 0.01), 1);
    t_pr = $realtime;
    #1;
    chk("R3 pci pulse only while running", int'(osc_en && vco_en && !out_hold), 1);
  end
  always @(negedge pci_clk_out) begin
    t_pf = $realtime;
    if (t_pr >= 0.0)
      chk("R4 pci high width ns", $rtoi(t_pf - t_pr + 0.5), PCI_HALF * CLK_PERIOD);
  end
  always @(negedge osc_en) begin
    osc_falls++;
    #1;
    chk("R3 parked when oscillator stops", int'(out_hold && !cpu_clk_out && !pci_clk_out), 1);
  end

  task automatic cyc_wait(input int n);
    repeat (n) @(posedge cpu_clk);
    #1;
  endtask

  task automatic at_neg();
    @(negedge cpu_clk);
    #1;
  endtask

  task automatic win(input int n, output int dc, output int dp);
    int c0 = cpu_rises;
    int p0 = pci_rises;
    cyc_wait(n);
    dc = cpu_rises - c0;
    dp = pci_rises - p0;
  endtask

  task automatic full_cycle(input int ph);
    int c0, p0, e0, dc, dp;
    cyc_wait(ph);
    at_neg();
    pd_n = 1'b0;
    c0 = cpu_rises;
    cyc_wait(10);
    chk("R2 cpu edges after request", cpu_rises - c0, 2);
    chk("R3 enables off and held", int'({osc_en, vco_en, out_hold}), 1);
    c0 = cpu_rises; p0 = pci_rises;
    cyc_wait(5);
    chk("R3 silent while off", (cpu_rises - c0) + (pci_rises - p0), 0);
    at_neg();
    pd_n = 1'b1;
    @(posedge osc_en); #1;
    chk("R5 vco still off at crystal start", int'({vco_en, out_hold}), 1);
    e0 = eff;
    @(posedge vco_en); #1;
    chk("R5 one tick crystal to vco", eff - e0, 1);
    e0 = eff;
    @(negedge out_hold); #1;
    chk("R6 settle ticks", eff - e0, SETTLE);
    cyc_wait(12);
    win(16, dc, dp);
    chk("R6 cpu runs after release", dc, 16);
    chk("R6 pci runs after release", dp, 16 / (2 * PCI_HALF));
  endtask

  initial begin
    int dc, dp, c0, p0, f0;
    logic [2:0] snap;
    repeat (3) @(posedge cpu_clk);
    at_neg();
    rst_n = 1'b1;

    // R1 reset state
    cyc_wait(6);
    chk("R1 reset enables/hold", int'({osc_en, vco_en, out_hold}), 6);
    win(16, dc, dp);
    chk("R1 cpu rate", dc, 16);
    chk("R1 pci rate", dp, 16 / (2 * PCI_HALF));

    // R10 stop inputs while running
    at_neg(); cpu_stop_n = 1'b0;
    cyc_wait(8);
    win(16, dc, dp);
    chk("R10 cpu parked by cpu stop", dc, 0);
    chk("R10 pci unaffected by cpu stop", dp, 4);
    at_neg(); cpu_stop_n = 1'b1; pci_stop_n = 1'b0;
    cyc_wait(8);
    win(16, dc, dp);
    chk("R10 cpu unaffected by pci stop", dc, 16);
    chk("R10 pci parked by pci stop", dp, 0);
    at_neg(); pci_stop_n = 1'b1;
    cyc_wait(8);
    win(16, dc, dp);
    chk("R10 cpu resumes", dc, 16);
    chk("R10 pci resumes", dp, 4);

    // sweep request edge across timer and PCI phases
    for (int ph = 0; ph < 2 * TDIV; ph++) full_cycle(ph);

    // R7 release while parking
    at_neg(); pd_n = 1'b0;
    @(posedge out_hold); #1;
    f0 = osc_falls;
    at_neg(); pd_n = 1'b1;
    @(negedge out_hold); #1;
    chk("R7 shutdown completed before restart", osc_falls - f0, 1);
    cyc_wait(12);

    // R8 reassert during settle, then during crystal start
    at_neg(); pd_n = 1'b0;
    cyc_wait(10);
    at_neg(); pd_n = 1'b1;
    @(posedge vco_en); #1;
    at_neg(); pd_n = 1'b0;
    c0 = cpu_rises; p0 = pci_rises;
    cyc_wait(6);
    chk("R8 off after reassert in settle", int'({osc_en, vco_en, out_hold}), 1);
    chk("R8 no pulses", (cpu_rises - c0) + (pci_rises - p0), 0);
    at_neg(); pd_n = 1'b1;
    @(posedge osc_en); #1;
    at_neg(); pd_n = 1'b0;
    c0 = cpu_rises; p0 = pci_rises;
    cyc_wait(6);
    chk("R8 off after reassert at crystal start", int'({osc_en, vco_en, out_hold}), 1);
    chk("R8 no pulses at crystal start", (cpu_rises - c0) + (pci_rises - p0), 0);

    // R9 stop inputs ignored while held
    cyc_wait(4);
    snap = {osc_en, vco_en, out_hold};
    for (int k = 0; k < 6; k++) begin
      at_neg();
      cpu_stop_n = ~cpu_stop_n;
      pci_stop_n = (k % 3 == 0) ? ~pci_stop_n : pci_stop_n;
      c0 = cpu_rises; p0 = pci_rises;
      cyc_wait(3);
      chk("R9 state unchanged by stops", int'({osc_en, vco_en, out_hold}), int'(snap));
      chk("R9 no pulses from stops", (cpu_rises - c0) + (pci_rises - p0), 0);
    end
    at_neg(); cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
    cyc_wait(2);
    at_neg(); pd_n = 1'b1;
    @(negedge out_hold); #1;
    cyc_wait(8);
    win(16, dc, dp);
    chk("R10 stops honoured after restart cpu", dc, 0);
    chk("R10 stops honoured after restart pci", dp, 0);
    at_neg(); cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    cyc_wait(8);
    win(16, dc, dp);
    chk("R6 cpu after stops released", dc, 16);
    chk("R6 pci after stops released", dp, 4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule